// File: doc/BRIEF.md
# Rotor Stall Protection Supervisor

This block guards a spindle motor drive against a rotor that never reaches speed lock. While the run command is asserted and the lock loop reports "unlocked", a timer advances once per timebase tick. If lock is still missing after a programmable number of ticks, the block latches a fault that switches off the low-side drive. The only ways to clear the fault are a stop command or a power-on reset. A stall, a jammed rotor and a missing reference clock all look the same to the block: the lock never comes, so drive is shut off after a short spin.

The same tick timebase holds the rest of the drive logic in reset for a fixed number of ticks after power-on reset is released. A frequency-change deceleration flag freezes the stall timer so that a commanded slow-down cannot trip the protection. A bypass input turns stall protection off and leaves the initial reset working. All analog capacitor timing is replaced by a clock prescaler and counters.

Top module: `stall_sup`

## Requirements
- R1: While `rstN` is low, `driveKill` is 0 and `logicRst` is 1.
- R2: One tick occurs every `PRESCALE` clock cycles. The first tick falls on the `PRESCALE`-th rising edge after reset release. `logicRst` stays 1 until `INIT_TICKS` ticks have passed. It then falls and stays 0 until the next power-on reset.
- R3: A counting tick is a tick at which `runCmd`=1, `unlocked`=1, `decel`=0, `protDisable`=0 and `logicRst`=0. `driveKill` rises one cycle after the counting tick at which `timeoutTicks`+1 counting ticks have been seen without a clear. When `timeoutTicks` is 0, it rises after the first counting tick.
- R4: Any cycle with `unlocked`=0 (lock reached) resets the stall timer to zero.
- R5: While `decel`=1, the stall timer neither advances nor clears. Counting resumes from the frozen value.
- R6: Once set, `driveKill` stays 1 while `runCmd` stays 1, whatever `unlocked`, `decel` and `protDisable` do.
- R7: Any cycle with `runCmd`=0 clears `driveKill` and the stall timer at the next edge.
- R8: While `protDisable`=1, the stall timer is held at zero and no new fault is set. Initial reset timing is unaffected.
- R9: While `logicRst`=1, the stall timer does not run and `driveKill` cannot rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, active low |
| runCmd | input | 1 | 1 = motor commanded to run, 0 = stop |
| unlocked | input | 1 | 1 = speed loop not in lock |
| decel | input | 1 | 1 = deceleration after a reference frequency change |
| protDisable | input | 1 | 1 = bypass stall protection |
| timeoutTicks | input | CNT_W | Stall timeout, in ticks |
| driveKill | output | 1 | Latched fault: 1 = low-side drive off |
| logicRst | output | 1 | Initial reset for the drive logic, active high |

## Verification
The assertions assume that `runCmd`, `unlocked`, `decel` and `protDisable` are synchronous to `clk` and settle between edges. They also assume that `timeoutTicks` is treated as a static setting while the timer is running. The stimulus changes every input only at the falling edge. It picks `timeoutTicks` again only in stop phases, where the timer is already clear. The random phases hold each input pattern for several ticks, and `runCmd` is biased high so that the fault latch is reached often.

// File: rtl/stall_sup_pkg.sv
package stall_sup_pkg;
  typedef struct packed {
    logic countEn;
    logic clearCnt;
  } dpStrobe_t;

  typedef struct packed {
    logic tick;
    logic initDone;
    logic timeoutHit;
  } dpStatus_t;
endpackage

// File: rtl/stall_sup_dp.sv
module stall_sup_dp
  import stall_sup_pkg::*;
#(
  parameter int PRESCALE   = 16,
  parameter int INIT_TICKS = 8,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] timeoutTicks,
  input  dpStrobe_t        strobe,
  output dpStatus_t        status
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int IW = $clog2(INIT_TICKS + 1);
  localparam logic [PW-1:0] PRE_MAX  = PW'(PRESCALE - 1);
  localparam logic [IW-1:0] INIT_END = IW'(INIT_TICKS);

  logic [PW-1:0]    preCnt;
  logic [IW-1:0]    initCnt;
  logic [CNT_W-1:0] stallCnt;

  always_comb begin
    status.tick       = (preCnt == PRE_MAX);
    status.initDone   = (initCnt == INIT_END);
    status.timeoutHit = (stallCnt >= timeoutTicks);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (status.tick) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initCnt <= '0;
    else if (status.tick && !status.initDone) initCnt <= initCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stallCnt <= '0;
    else if (strobe.clearCnt) stallCnt <= '0;
    else if (strobe.countEn && !status.timeoutHit) stallCnt <= stallCnt + 1'b1;
  end

  // R2
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    status.initDone |=> status.initDone);

  // R5
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.clearCnt) |=> $stable(stallCnt));
endmodule

// File: rtl/stall_sup_ctrl.sv
module stall_sup_ctrl
  import stall_sup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      runCmd,
  input  logic      unlocked,
  input  logic      decel,
  input  logic      protDisable,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      driveKill,
  output logic      logicRst
);
  logic faultQ;
  logic armed;
  logic setFault;

  always_comb begin
    armed           = runCmd && unlocked && !protDisable && status.initDone && !faultQ;
    strobe.clearCnt = !runCmd || !unlocked || protDisable || !status.initDone;
    strobe.countEn  = status.tick && armed && !decel;
    setFault        = strobe.countEn && status.timeoutHit;
    driveKill       = faultQ;
    logicRst        = !status.initDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultQ <= 1'b0;
    else if (!runCmd) faultQ <= 1'b0;
    else if (setFault) faultQ <= 1'b1;
  end

  // R6
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveKill) |-> $past(!runCmd));

  // R7
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runCmd |=> !driveKill);

  // R3
  trip_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveKill) |-> $past(runCmd && unlocked && !decel && status.tick));

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protDisable && !driveKill) |=> !driveKill);

  // R9
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    logicRst |-> !driveKill);
endmodule

// File: rtl/stall_sup.sv
module stall_sup
  import stall_sup_pkg::*;
#(
  parameter int PRESCALE   = 16,
  parameter int INIT_TICKS = 8,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runCmd,
  input  logic             unlocked,
  input  logic             decel,
  input  logic             protDisable,
  input  logic [CNT_W-1:0] timeoutTicks,
  output logic             driveKill,
  output logic             logicRst
);
  dpStrobe_t strobe;
  dpStatus_t status;

  stall_sup_dp #(
    .PRESCALE(PRESCALE), .INIT_TICKS(INIT_TICKS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .timeoutTicks(timeoutTicks),
    .strobe(strobe), .status(status)
  );

  stall_sup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runCmd(runCmd), .unlocked(unlocked),
    .decel(decel), .protDisable(protDisable), .status(status),
    .strobe(strobe), .driveKill(driveKill), .logicRst(logicRst)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |-> (!driveKill && logicRst));
endmodule

// File: tb/stall_sup_bench.sv
module stall_sup_bench;
  localparam int P  = 4;
  localparam int I  = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runCmd = 1'b0, unlocked = 1'b0, decel = 1'b0, protDisable = 1'b0;
  logic [CW-1:0] timeoutTicks = '0;
  logic driveKill, logicRst;

  int errors = 0, checks = 0, cycles = 0;
  string phase = "R1";

  // reference state
  int mPre = 0, mInit = 0, mStall = 0;
  bit mFault = 0;

  always #2.5 clk = ~clk;

  stall_sup #(.PRESCALE(P), .INIT_TICKS(I), .CNT_W(CW)) u_stall_sup (
    .clk(clk), .rstN(rstN), .runCmd(runCmd), .unlocked(unlocked),
    .decel(decel), .protDisable(protDisable), .timeoutTicks(timeoutTicks),
    .driveKill(driveKill), .logicRst(logicRst)
  );

  function automatic bit expKill();
    return mFault;
  endfunction

  function automatic bit expRst();
    return (mInit != I);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic modelEdge();
    bit tick, done, hit, clr, cen, sf;
    tick = (mPre == P - 1);
    done = (mInit == I);
    hit  = (mStall >= int'(timeoutTicks));
    clr  = !runCmd || !unlocked || protDisable || !done;
    cen  = tick && runCmd && unlocked && !protDisable && done && !mFault && !decel;
    sf   = cen && hit;
    mPre = tick ? 0 : mPre + 1;
    if (tick && !done) mInit++;
    if (clr) mStall = 0;
    else if (cen && !hit) mStall++;
    if (!runCmd) mFault = 0;
    else if (sf) mFault = 1;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      cycles++;
      if (rstN) modelEdge();
      @(negedge clk);
      chk({phase, " driveKill"}, driveKill, expKill());
      chk({phase, " logicRst"}, logicRst, expRst());
    end
  endtask

  task automatic setIn(input bit r, input bit u, input bit d, input bit x);
    runCmd = r; unlocked = u; decel = d; protDisable = x;
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    @(negedge clk);
    step(3);
    chk("R1 driveKill in reset", driveKill, 1'b0);
    chk("R1 logicRst in reset", logicRst, 1'b1);
    rstN = 1'b1;

    // R2 and R9: run while unlocked during initial reset
    phase = "R2/R9";
    timeoutTicks = 8'd0;
    setIn(1, 1, 0, 0);
    step(P * I - 1);
    chk("R2 still in init reset", logicRst, 1'b1);
    chk("R9 no kill during init", driveKill, 1'b0);
    step(1);
    chk("R2 init reset released", logicRst, 1'b0);
    // R3 timeout 0: first counting tick trips
    phase = "R3";
    step(P);
    chk("R3 zero timeout trip", driveKill, 1'b1);

    // R7: stop clears
    phase = "R7";
    setIn(0, 1, 0, 0);
    step(1);
    chk("R7 stop clears kill", driveKill, 1'b0);

    // R3: timeout 5 needs 6 counting ticks
    phase = "R3";
    timeoutTicks = 8'd5;
    step(2);
    setIn(1, 1, 0, 0);
    step(P * 5);
    chk("R3 not yet tripped", driveKill, 1'b0);
    step(P * 2);
    chk("R3 tripped after timeout", driveKill, 1'b1);
    // R6: latch holds with lock regained
    phase = "R6";
    setIn(1, 0, 1, 1);
    step(P * 3);
    chk("R6 kill stays latched", driveKill, 1'b1);

    // R4: lock resets timer
    phase = "R4";
    setIn(0, 0, 0, 0);
    step(2);
    setIn(1, 1, 0, 0);
    step(P * 4);
    setIn(1, 0, 0, 0);
    step(1);
    setIn(1, 1, 0, 0);
    step(P * 5);
    chk("R4 lock restarted count", driveKill, 1'b0);
    step(P * 3);

    // R5: decel freezes
    phase = "R5";
    setIn(0, 0, 0, 0);
    step(2);
    setIn(1, 1, 0, 0);
    step(P * 3);
    setIn(1, 1, 1, 0);
    step(P * 10);
    chk("R5 decel holds off trip", driveKill, 1'b0);
    setIn(1, 1, 0, 0);
    step(P * 4);

    // R8: bypass
    phase = "R8";
    setIn(0, 0, 0, 0);
    step(2);
    setIn(1, 1, 0, 1);
    step(P * 12);
    chk("R8 bypass prevents trip", driveKill, 1'b0);

    // random phases
    phase = "R3-R8 random";
    for (int n = 0; n < 400; n++) begin
      bit r, u, d, x;
      r = ($urandom_range(9) != 0);
      u = ($urandom_range(3) != 0);
      d = ($urandom_range(7) == 0);
      x = ($urandom_range(9) == 0);
      if (!r) timeoutTicks = CW'($urandom_range(12));
      setIn(r, u, d, x);
      step($urandom_range(1, P * 8));
    end

    // R1 and R2: second power-on reset
    phase = "R1 repeat";
    rstN = 1'b0;
    mPre = 0; mInit = 0; mStall = 0; mFault = 0;
    step(2);
    chk("R1 reset re-entered", logicRst, 1'b1);
    rstN = 1'b1;
    phase = "R2 repeat";
    step(P * I + 2);
    chk("R2 reset released again", logicRst, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule